// File: doc/BRIEF.md
# Configuration port access controller

This block connects a simple request/response register interface to a synchronous configuration port on a slave such as a transceiver. The requester offers a read or a write with an address and, for writes, a 16-bit data word. The controller takes one request at a time, places it on the port as a single-cycle enable strobe with address, write data and a write qualifier, and waits for the slave's ready return. That return completes a write, and for a read it also marks the slave's read-data bus as valid.

Read data is captured in a holding register in the ready cycle and handed back with a one-cycle done pulse. If ready never comes within a programmable number of cycles, the controller gives up, pulses an error flag and goes back to idle. While a transaction is in flight the request side sees a low ready and must keep its request waiting. The request is not lost.

The state machine has five states. IDLE waits for a request. ISSUE drives the enable strobe. WAIT counts cycles until ready or expiry. DONE pulses completion. ABORT pulses the error. The transitions are:

- IDLE to ISSUE when a request is accepted.
- ISSUE to WAIT always.
- WAIT to DONE when ready is seen.
- WAIT to ABORT when the limit runs out without ready.
- DONE to IDLE and ABORT to IDLE always.

Top module: `cfgport_bridge`

## Requirements
- R1: After synchronous active-high reset the controller is idle: `req_ready` is 1, and `cp_en`, `cp_we`, `rsp_done` and `rsp_error` are 0.
- R2: A request seen with `req_valid` and `req_ready` both high at a clock edge produces `cp_en` high in the next cycle. In that cycle `cp_addr` and `cp_wdata` carry the request's address and data, and `cp_we` carries `req_write` (1 = write, 0 = read).
- R3: From acceptance until the cycle after the response pulse, `req_ready` is 0. A request held on `req_valid` during that time is neither dropped nor issued. It is accepted at the first idle cycle.
- R4: Exactly one `cp_en` pulse is issued per accepted request. No new `cp_en` appears before the previous transaction's `rsp_done` or `rsp_error`.
- R5: If `cp_rdy` is high in wait cycle k, where k is at most the limit L, `rsp_done` is high for exactly one cycle, in cycle k+1 after the enable cycle. For a read, `rsp_rdata` then equals the `cp_rdata` word presented with `cp_rdy`.
- R6: If `cp_rdy` stays low for L wait cycles, `rsp_error` is high for exactly one cycle, in cycle L+1 after the enable cycle, and the controller returns to idle. A limit of 0 behaves as 1. `rsp_done` and `rsp_error` are never high together.
- R7: `cp_rdy` arriving while the controller is idle has no effect: no response pulse, no enable, and `rsp_rdata` is unchanged.
- R8: `cp_we` is high only in a cycle where `cp_en` is high.
- R9: `rsp_rdata` changes only when a read completes with `rsp_done`. Write completions and aborts leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both interfaces |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| req_ready | output | 1 | Controller idle and able to take a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | One-cycle timeout pulse |
| rsp_rdata | output | DW | Held read data of the last completed read |
| tmo_limit | input | TW | Number of wait cycles allowed for ready |
| cp_en | output | 1 | Single-cycle operation strobe to the slave |
| cp_we | output | 1 | Write qualifier, valid with `cp_en` |
| cp_addr | output | AW | Port address |
| cp_wdata | output | DW | Port write data |
| cp_rdata | input | DW | Port read data, valid with `cp_rdy` |
| cp_rdy | input | 1 | Slave completion / read-data valid |

## Verification
The assertions assume the slave never raises `cp_rdy` in the enable cycle itself. They also assume `tmo_limit` stays constant while a transaction is in flight. The bench's slave model meets both assumptions: it starts counting its latency only after it samples the strobe, and the bench changes the limit only while the controller is idle. After each timeout the bench also waits long enough for a late ready from the slave model to land while idle, so no stale ready can leak into the next transaction.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_DONE  = 3'd3,
        ST_ABORT = 3'd4
    } cp_state_e;

endpackage

// File: rtl/cfgport_timer.sv
module cfgport_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    localparam int CW = TW + 1;

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // the current wait cycle is cnt_q+1; a limit of 0 counts as 1
    assign expired = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, limit};

endmodule

// File: rtl/cfgport_hold.sv
module cfgport_hold #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          in_write,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic          capture,
    input  logic [DW-1:0] port_rdata,
    output logic          lat_write,
    output logic [AW-1:0] lat_addr,
    output logic [DW-1:0] lat_wdata,
    output logic [DW-1:0] rd_hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_write <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (load) begin
            lat_write <= in_write;
            lat_addr  <= in_addr;
            lat_wdata <= in_wdata;
        end
    end

    // only reads update the returned word
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hold <= '0;
        end else if (capture && !lat_write) begin
            rd_hold <= port_rdata;
        end
    end

endmodule

// File: rtl/cfgport_fsm.sv
module cfgport_fsm
    import cfgport_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  logic      port_rdy,
    input  logic      expired,
    output cp_state_e state,
    output logic      accept,
    output logic      strobe,
    output logic      tmr_clr,
    output logic      tmr_run,
    output logic      capture,
    output logic      done,
    output logic      error
);
    cp_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) nxt = ST_ISSUE;
            ST_ISSUE: nxt = ST_WAIT;
            ST_WAIT: begin
                if (port_rdy)     nxt = ST_DONE;
                else if (expired) nxt = ST_ABORT;
            end
            ST_DONE:  nxt = ST_IDLE;
            ST_ABORT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept  = 1'b0;
        strobe  = 1'b0;
        tmr_clr = 1'b0;
        tmr_run = 1'b0;
        capture = 1'b0;
        done    = 1'b0;
        error   = 1'b0;
        unique case (state)
            ST_IDLE:  accept = req_valid;
            ST_ISSUE: begin
                strobe  = 1'b1;
                tmr_clr = 1'b1;
            end
            ST_WAIT: begin
                tmr_run = 1'b1;
                capture = port_rdy;
            end
            ST_DONE:  done  = 1'b1;
            ST_ABORT: error = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
    import cfgport_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_done,
    output logic          rsp_error,
    output logic [DW-1:0] rsp_rdata,
    input  logic [TW-1:0] tmo_limit,
    output logic          cp_en,
    output logic          cp_we,
    output logic [AW-1:0] cp_addr,
    output logic [DW-1:0] cp_wdata,
    input  logic [DW-1:0] cp_rdata,
    input  logic          cp_rdy
);
    cp_state_e state;
    logic accept, strobe, tmr_clr, tmr_run, capture, expired, lat_write;

    cfgport_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .port_rdy  (cp_rdy),
        .expired   (expired),
        .state     (state),
        .accept    (accept),
        .strobe    (strobe),
        .tmr_clr   (tmr_clr),
        .tmr_run   (tmr_run),
        .capture   (capture),
        .done      (rsp_done),
        .error     (rsp_error)
    );

    cfgport_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .limit   (tmo_limit),
        .expired (expired)
    );

    cfgport_hold #(.AW(AW), .DW(DW)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .in_write   (req_write),
        .in_addr    (req_addr),
        .in_wdata   (req_wdata),
        .capture    (capture),
        .port_rdata (cp_rdata),
        .lat_write  (lat_write),
        .lat_addr   (cp_addr),
        .lat_wdata  (cp_wdata),
        .rd_hold    (rsp_rdata)
    );

    assign req_ready = (state == ST_IDLE);
    assign cp_en     = strobe;
    assign cp_we     = strobe & lat_write;

endmodule

module cfgport_bridge_chk #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic          req_ready,
    input logic          rsp_done,
    input logic          rsp_error,
    input logic [DW-1:0] rsp_rdata,
    input logic          cp_en,
    input logic          cp_we,
    input logic [AW-1:0] cp_addr,
    input logic          cp_rdy
);
    logic pending_q;

    always_ff @(posedge clk) begin
        if (rst)                       pending_q <= 1'b0;
        else if (cp_en)                pending_q <= 1'b1;
        else if (rsp_done || rsp_error) pending_q <= 1'b0;
    end

    // R2
    strobe_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cp_en && cp_we == $past(req_write) && cp_addr == $past(req_addr)));

    // R3
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (cp_en || pending_q) |-> !req_ready);

    // R4
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        cp_en |-> !pending_q);

    // R5
    done_after_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(cp_rdy));

    // R6
    resp_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_done && rsp_error));

    // R9
    rdata_only_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rsp_rdata) |-> rsp_done);

endmodule

bind cfgport_bridge cfgport_bridge_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_error (rsp_error),
    .rsp_rdata (rsp_rdata),
    .cp_en     (cp_en),
    .cp_we     (cp_we),
    .cp_addr   (cp_addr),
    .cp_rdy    (cp_rdy)
);

// File: tb/test_cfgport_bridge.sv
module cfgport_slave_model #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [3:0]    lat,
    input  logic          spur,
    output logic          rdy,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [16];
    logic [3:0]    cnt;
    logic [3:0]    ra;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ra  <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= DW'(16'hC3A0 + i * 16'h0111);
        end else begin
            if (en) begin
                cnt <= lat;
                ra  <= addr[3:0];
                if (we) mem[addr[3:0]] <= wdata;
            end else if (cnt != 0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign rdy   = (cnt == 4'd1) || spur;
    assign rdata = rdy ? mem[ra] : '0;
endmodule

module test_cfgport_bridge;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [TW-1:0] tmo_limit = 4'd4;
    logic req_ready, rsp_done, rsp_error, cp_en, cp_we, cp_rdy;
    logic [DW-1:0] rsp_rdata, cp_wdata, cp_rdata;
    logic [AW-1:0] cp_addr;
    logic [3:0] slv_lat = 4'd1;
    logic slv_spur = 1'b0;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] exp_mem [16];
    logic [DW-1:0] last_rd = '0;

    always #5 clk = ~clk;

    cfgport_bridge #(.AW(AW), .DW(DW), .TW(TW)) i_cfgport_bridge (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .tmo_limit(tmo_limit), .cp_en(cp_en), .cp_we(cp_we), .cp_addr(cp_addr),
        .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_rdy(cp_rdy)
    );

    cfgport_slave_model #(.AW(AW), .DW(DW)) u_slave (
        .clk(clk), .rst(rst), .en(cp_en), .we(cp_we), .addr(cp_addr),
        .wdata(cp_wdata), .lat(slv_lat), .spur(slv_spur), .rdy(cp_rdy), .rdata(cp_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int lat, input int lim);
        int en_seen, resp_n, eff, m;
        bit got_done, got_err, exp_done;
        logic [DW-1:0] rdv;
        @(negedge clk);
        slv_lat = 4'(lat);
        tmo_limit = TW'(lim);
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(cp_en && cp_we == we && cp_addr == a && cp_wdata == d, "R2", "strobe fields",
            {cp_en, cp_we, cp_addr, cp_wdata}, {1'b1, we, a, d});
        chk(!we || cp_we, "R8", "we with enable", cp_we, we);
        if (we) exp_mem[a[3:0]] = d;
        en_seen = 1; resp_n = 0; got_done = 0; got_err = 0; rdv = '0;
        for (int k = 2; k <= 40; k++) begin
            @(negedge clk);
            if (cp_en) en_seen++;
            chk(!cp_we || cp_en, "R8", "we without enable", cp_we, 0);
            if (rsp_done || rsp_error) begin
                resp_n = k; got_done = rsp_done; got_err = rsp_error; rdv = rsp_rdata;
                break;
            end
            chk(!req_ready, "R3", "ready while busy", req_ready, 0);
        end
        eff = (lim == 0) ? 1 : lim;
        exp_done = (lat != 0) && (lat <= eff);
        m = exp_done ? lat : eff;
        chk(en_seen == 1, "R4", "enable count", en_seen, 1);
        chk(resp_n == 2 + m, exp_done ? "R5" : "R6", "response cycle", resp_n, 2 + m);
        chk(got_done == exp_done && got_err == !exp_done, exp_done ? "R5" : "R6",
            "response kind", {got_done, got_err}, {exp_done, !exp_done});
        if (exp_done && !we) begin
            chk(rdv == exp_mem[a[3:0]], "R5", "read data", rdv, exp_mem[a[3:0]]);
            last_rd = exp_mem[a[3:0]];
        end else begin
            chk(rdv == last_rd, "R9", "held data unchanged", rdv, last_rd);
        end
        // pulse is one cycle, late ready after abort lands while idle
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(!rsp_done && !rsp_error && !cp_en && req_ready, exp_done ? "R5" : "R7",
                "quiet after response", {rsp_done, rsp_error, cp_en, req_ready}, 4'b0001);
            if (k > 0 && !exp_done) k = 10;
        end
        slv_lat = 4'(lat);
        repeat (8) @(negedge clk);
    endtask

    task automatic backpressure_test();
        bit responded;
        int stall_bad;
        @(negedge clk);
        slv_lat = 4'd6; tmo_limit = 4'd8;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 6'd3;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd5; req_wdata = 16'hBEEF;
        responded = 0; stall_bad = 0;
        for (int k = 3; k <= 20; k++) begin
            @(negedge clk);
            if (rsp_done) begin responded = 1; break; end
            if (req_ready || cp_en) stall_bad++;
        end
        chk(responded && stall_bad == 0, "R3", "held request stalls", stall_bad, 0);
        chk(rsp_rdata == exp_mem[3], "R5", "first read data", rsp_rdata, exp_mem[3]);
        last_rd = exp_mem[3];
        @(negedge clk);
        chk(req_ready, "R3", "ready after response", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(cp_en && cp_we && cp_addr == 6'd5 && cp_wdata == 16'hBEEF, "R3",
            "held request issued", {cp_en, cp_we, cp_addr, cp_wdata}, {2'b11, 6'd5, 16'hBEEF});
        exp_mem[5] = 16'hBEEF;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (rsp_done) break;
        end
        repeat (3) @(negedge clk);
        run_txn(1'b0, 6'd5, '0, 2, 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) exp_mem[i] = DW'(16'hC3A0 + i * 16'h0111);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !cp_en && !cp_we && !rsp_done && !rsp_error, "R1", "reset state",
            {req_ready, cp_en, cp_we, rsp_done, rsp_error}, 5'b10000);
        chk(rsp_rdata == '0, "R1", "reset data", rsp_rdata, 0);

        // R7 spurious ready while idle
        @(negedge clk); slv_spur = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!rsp_done && !rsp_error && !cp_en && req_ready && rsp_rdata == '0, "R7",
                "spurious ready ignored", {rsp_done, rsp_error, cp_en, req_ready}, 4'b0001);
        end
        slv_spur = 1'b0;

        // sweep of limit, latency and direction
        for (int lim = 0; lim <= 5; lim++) begin
            for (int lat = 0; lat <= 7; lat++) begin
                for (int w = 0; w < 2; w++) begin
                    run_txn(w[0], AW'(lim * 8 + lat), DW'(16'h1000 * lim + 16'h0101 * lat + w),
                            lat, lim);
                end
            end
        end

        backpressure_test();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule